// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer and Decoder

This block sits next to a processor whose 20 bus lines are shared in time between address, data and status. In the first clock of each bus cycle the processor raises a latch strobe while the 16 low lines carry address bits 15..0 and the 4 upper lines carry bits 19..16. The block captures the full 20-bit address and the active-low bank-high enable at that point and holds both for the rest of the cycle. In the later clocks it decodes the segment status pair on the upper lines into a one-hot indicator and moves data between the processor lines and the system side.

The block also turns the single read and write strobes and the memory/IO select into four separate active-low commands. From the low address bit and the latched bank-high enable it produces low-bank and high-bank selects, and it flags the combination that selects neither bank. Write data is driven toward the system only while the direction input says transmit and the write strobe is active. Read data is driven toward the processor only while the direction says receive and the read strobe is active. All control pins are plain level signals. No stream of items flows through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `mux_bus_splitter`

## Requirements
- R1: After synchronous reset (rst_n low at a rising edge) the held address is 0 and the held bank-high enable is 1, so with the strobe low addr_o is 0, lo_bank_o is 1, hi_bank_o is 0 and bank_err_o is 0.
- R2: While latch_stb_i is 1, addr_o equals {mux_hi_i, mux_lo_i} in the same cycle, and the bank outputs follow bhe_n_i and mux_lo_i[0] in that cycle.
- R3: The address and bank-high enable present at the last rising edge with latch_stb_i high are held on addr_o and the bank outputs for as long as latch_stb_i stays low.
- R4: While latch_stb_i is 0, seg_o is one-hot with bit index {mux_hi_i[1], mux_hi_i[0]}: bit 0 extra, bit 1 stack, bit 2 code or none, bit 3 data. While latch_stb_i is 1, seg_o is 0.
- R5: lo_bank_o is 1 exactly when the current address bit 0 is 0; hi_bank_o is 1 exactly when the current bank-high enable is 0. Both high is a 16-bit word access.
- R6: bank_err_o is 1 exactly when address bit 0 is 1 and the bank-high enable is 1, and then neither bank select is asserted.
- R7: mem_rd_n_o is 0 exactly when rd_n_i is 0 and mem_sel_i is 1; io_rd_n_o is 0 exactly when rd_n_i is 0 and mem_sel_i is 0; mem_wr_n_o and io_wr_n_o follow wr_n_i the same way.
- R8: With rd_n_i and wr_n_i both 1, all four command outputs are 1 whatever mem_sel_i is.
- R9: wdata_oe_o is 1 and wdata_o equals mux_lo_i exactly when dir_tx_i is 1 and wr_n_i is 0; otherwise wdata_oe_o is 0 and wdata_o is 0.
- R10: rdata_oe_o is 1 and rdata_o equals ext_rdata_i exactly when dir_tx_i is 0 and rd_n_i is 0; otherwise rdata_oe_o is 0 and rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mux_lo_i | input | 16 | Low shared lines: address 15..0, then data |
| mux_hi_i | input | 4 | Upper shared lines: address 19..16, then status |
| latch_stb_i | input | 1 | Address latch strobe, active high |
| bhe_n_i | input | 1 | Bank-high enable, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| mem_sel_i | input | 1 | 1 selects memory, 0 selects I/O |
| dir_tx_i | input | 1 | Transceiver direction, 1 transmit |
| ext_rdata_i | input | 16 | Read data from the system side |
| addr_o | output | 20 | Demultiplexed address |
| seg_o | output | 4 | One-hot segment indicator |
| lo_bank_o | output | 1 | Low byte bank select |
| hi_bank_o | output | 1 | High byte bank select |
| bank_err_o | output | 1 | No bank selected |
| mem_rd_n_o | output | 1 | Memory read, active low |
| mem_wr_n_o | output | 1 | Memory write, active low |
| io_rd_n_o | output | 1 | I/O read, active low |
| io_wr_n_o | output | 1 | I/O write, active low |
| wdata_o | output | 16 | Write data toward the system |
| wdata_oe_o | output | 1 | Write data driven |
| rdata_o | output | 16 | Read data toward the processor |
| rdata_oe_o | output | 1 | Read data driven |

## Verification
The bench runs word, even-byte, odd-byte and invalid-bank cycles to memory and I/O with status values for all four segments, and compares every output against its model on each clock. It targets the hold after the strobe falls: a latch that stayed transparent would show data words on addr_o in later clocks, and one that captured late would show the previous cycle's address during the strobe clock. An odd address with the bank-high enable inactive checks that the error flag rises and neither bank is selected, where a wrong polarity would enable a bank. Cycles with both strobes idle and mixed direction settings catch a command or a driver that leaks through its gating.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  localparam int unsigned LO_W  = 16;
  localparam int unsigned HI_W  = 4;
  localparam int unsigned SEG_W = 2;
  localparam int unsigned NSEG  = 1 << SEG_W;

  typedef enum logic [SEG_W-1:0] {
    SEG_EXTRA = 2'b00,
    SEG_STACK = 2'b01,
    SEG_CODE  = 2'b10,
    SEG_DATA  = 2'b11
  } seg_e;

  typedef struct packed {
    logic [HI_W-1:0] hi;
    logic [LO_W-1:0] lo;
    logic            bhe_n;
  } latch_t;
endpackage

// File: rtl/mbs_addr_latch.sv
module mbs_addr_latch
  import mbs_pkg::*;
#(
  parameter int unsigned LW = LO_W,
  parameter int unsigned HW = HI_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic [LW-1:0] lo_in,
  input  logic [HW-1:0] hi_in,
  input  logic          bhe_n_in,
  output logic [LW+HW-1:0] addr,
  output logic          bhe_n_cur
);
  localparam int unsigned AW = LW + HW;

  logic [AW-1:0] held_addr;
  logic          held_bhe_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_addr  <= '0;
      held_bhe_n <= 1'b1;
    end else if (stb) begin
      held_addr  <= {hi_in, lo_in};
      held_bhe_n <= bhe_n_in;
    end
  end

  // transparent while strobe is high, holds afterwards
  always_comb begin
    if (stb) begin
      addr      = {hi_in, lo_in};
      bhe_n_cur = bhe_n_in;
    end else begin
      addr      = held_addr;
      bhe_n_cur = held_bhe_n;
    end
  end
endmodule

// File: rtl/mbs_seg_decode.sv
module mbs_seg_decode
  import mbs_pkg::*;
#(
  parameter int unsigned SW = SEG_W,
  localparam int unsigned NS = 1 << SW
) (
  input  logic          en,
  input  logic [SW-1:0] code,
  output logic [NS-1:0] onehot
);
  for (genvar g = 0; g < NS; g++) begin : g_seg
    assign onehot[g] = en && (code == SW'(g));
  end
endmodule

// File: rtl/mbs_bank_cmd.sv
module mbs_bank_cmd (
  input  logic a0,
  input  logic bhe_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic mem_sel,
  output logic lo_bank,
  output logic hi_bank,
  output logic bank_err,
  output logic mem_rd_n,
  output logic mem_wr_n,
  output logic io_rd_n,
  output logic io_wr_n
);
  logic rd_act, wr_act;

  always_comb begin
    lo_bank  = ~a0;
    hi_bank  = ~bhe_n;
    bank_err = a0 & bhe_n;
    rd_act   = ~rd_n;
    wr_act   = ~wr_n;
    mem_rd_n = ~(rd_act &  mem_sel);
    io_rd_n  = ~(rd_act & ~mem_sel);
    mem_wr_n = ~(wr_act &  mem_sel);
    io_wr_n  = ~(wr_act & ~mem_sel);
  end
endmodule

// File: rtl/mbs_data_steer.sv
module mbs_data_steer #(
  parameter int unsigned DW = 16
) (
  input  logic          dir_tx,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] cpu_lines,
  input  logic [DW-1:0] sys_rdata,
  output logic [DW-1:0] wdata,
  output logic          wdata_oe,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe
);
  always_comb begin
    wdata_oe = dir_tx & ~wr_n;
    rdata_oe = ~dir_tx & ~rd_n;
    wdata    = wdata_oe ? cpu_lines : '0;
    rdata    = rdata_oe ? sys_rdata : '0;
  end
endmodule

// File: rtl/mux_bus_splitter.sv
module mux_bus_splitter
  import mbs_pkg::*;
#(
  parameter int unsigned LW = LO_W,
  parameter int unsigned HW = HI_W,
  parameter int unsigned SW = SEG_W,
  localparam int unsigned AW = LW + HW,
  localparam int unsigned NS = 1 << SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] mux_lo_i,
  input  logic [HW-1:0] mux_hi_i,
  input  logic          latch_stb_i,
  input  logic          bhe_n_i,
  input  logic          rd_n_i,
  input  logic          wr_n_i,
  input  logic          mem_sel_i,
  input  logic          dir_tx_i,
  input  logic [LW-1:0] ext_rdata_i,
  output logic [AW-1:0] addr_o,
  output logic [NS-1:0] seg_o,
  output logic          lo_bank_o,
  output logic          hi_bank_o,
  output logic          bank_err_o,
  output logic          mem_rd_n_o,
  output logic          mem_wr_n_o,
  output logic          io_rd_n_o,
  output logic          io_wr_n_o,
  output logic [LW-1:0] wdata_o,
  output logic          wdata_oe_o,
  output logic [LW-1:0] rdata_o,
  output logic          rdata_oe_o
);
  logic bhe_n_cur;

  mbs_addr_latch #(.LW(LW), .HW(HW)) u_latch (
    .clk(clk), .rst_n(rst_n), .stb(latch_stb_i),
    .lo_in(mux_lo_i), .hi_in(mux_hi_i), .bhe_n_in(bhe_n_i),
    .addr(addr_o), .bhe_n_cur(bhe_n_cur)
  );

  // status pair sits on the two lowest upper lines
  mbs_seg_decode #(.SW(SW)) u_seg (
    .en(~latch_stb_i), .code(mux_hi_i[SW-1:0]), .onehot(seg_o)
  );

  mbs_bank_cmd u_bank (
    .a0(addr_o[0]), .bhe_n(bhe_n_cur), .rd_n(rd_n_i), .wr_n(wr_n_i),
    .mem_sel(mem_sel_i), .lo_bank(lo_bank_o), .hi_bank(hi_bank_o),
    .bank_err(bank_err_o), .mem_rd_n(mem_rd_n_o), .mem_wr_n(mem_wr_n_o),
    .io_rd_n(io_rd_n_o), .io_wr_n(io_wr_n_o)
  );

  mbs_data_steer #(.DW(LW)) u_data (
    .dir_tx(dir_tx_i), .rd_n(rd_n_i), .wr_n(wr_n_i),
    .cpu_lines(mux_lo_i), .sys_rdata(ext_rdata_i),
    .wdata(wdata_o), .wdata_oe(wdata_oe_o),
    .rdata(rdata_o), .rdata_oe(rdata_oe_o)
  );
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
  parameter int unsigned AW = 20,
  parameter int unsigned NS = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          latch_stb_i,
  input logic          rd_n_i,
  input logic          wr_n_i,
  input logic [AW-1:0] addr_o,
  input logic [NS-1:0] seg_o,
  input logic          lo_bank_o,
  input logic          hi_bank_o,
  input logic          bank_err_o,
  input logic          mem_rd_n_o,
  input logic          mem_wr_n_o,
  input logic          io_rd_n_o,
  input logic          io_wr_n_o,
  input logic          wdata_oe_o
);
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_stb_i |=> (latch_stb_i || $stable(addr_o))); // R3
  AST_SEG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_stb_i |-> ($countones(seg_o) == 1)); // R4
  AST_SEG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb_i |-> (seg_o == '0)); // R4
  AST_BANK_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    bank_err_o |-> (!lo_bank_o && !hi_bank_o)); // R6
  AST_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n_i && wr_n_i) |-> (mem_rd_n_o && mem_wr_n_o && io_rd_n_o && io_wr_n_o)); // R8
  AST_WDRV_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_oe_o |-> (!mem_wr_n_o || !io_wr_n_o)); // R9
endmodule

bind mux_bus_splitter mbs_checker #(.AW(AW), .NS(NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .latch_stb_i(latch_stb_i),
  .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .addr_o(addr_o), .seg_o(seg_o),
  .lo_bank_o(lo_bank_o), .hi_bank_o(hi_bank_o), .bank_err_o(bank_err_o),
  .mem_rd_n_o(mem_rd_n_o), .mem_wr_n_o(mem_wr_n_o),
  .io_rd_n_o(io_rd_n_o), .io_wr_n_o(io_wr_n_o), .wdata_oe_o(wdata_oe_o)
);

// File: tb/tb_mux_bus_splitter.sv
module tb_mux_bus_splitter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] mux_lo_i = '0, ext_rdata_i = '0;
  logic [3:0]  mux_hi_i = '0;
  logic latch_stb_i = 0, bhe_n_i = 1, rd_n_i = 1, wr_n_i = 1, mem_sel_i = 1, dir_tx_i = 0;
  logic [19:0] addr_o;
  logic [3:0]  seg_o;
  logic lo_bank_o, hi_bank_o, bank_err_o;
  logic mem_rd_n_o, mem_wr_n_o, io_rd_n_o, io_wr_n_o;
  logic [15:0] wdata_o, rdata_o;
  logic wdata_oe_o, rdata_oe_o;

  int checks = 0, errors = 0, cycles = 0;
  logic [19:0] m_addr = '0;
  logic        m_bhe_n = 1'b1;

  mux_bus_splitter dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic compare();
    logic [19:0] ea;
    logic eb;
    logic [3:0] es;
    ea = latch_stb_i ? {mux_hi_i, mux_lo_i} : m_addr;  // R2 R3
    eb = latch_stb_i ? bhe_n_i : m_bhe_n;
    es = latch_stb_i ? 4'd0 : (4'd1 << mux_hi_i[1:0]);
    chk("R2/R3 addr", 32'(addr_o), 32'(ea));
    chk("R4 seg", 32'(seg_o), 32'(es));
    chk("R5 lo_bank", 32'(lo_bank_o), 32'(!ea[0]));
    chk("R5 hi_bank", 32'(hi_bank_o), 32'(!eb));
    chk("R6 bank_err", 32'(bank_err_o), 32'(ea[0] && eb));
    chk("R7/R8 mem_rd", 32'(mem_rd_n_o), 32'(!(!rd_n_i && mem_sel_i)));
    chk("R7/R8 io_rd", 32'(io_rd_n_o), 32'(!(!rd_n_i && !mem_sel_i)));
    chk("R7/R8 mem_wr", 32'(mem_wr_n_o), 32'(!(!wr_n_i && mem_sel_i)));
    chk("R7/R8 io_wr", 32'(io_wr_n_o), 32'(!(!wr_n_i && !mem_sel_i)));
    chk("R9 wdata_oe", 32'(wdata_oe_o), 32'(dir_tx_i && !wr_n_i));
    chk("R9 wdata", 32'(wdata_o), (dir_tx_i && !wr_n_i) ? 32'(mux_lo_i) : 32'd0);
    chk("R10 rdata_oe", 32'(rdata_oe_o), 32'(!dir_tx_i && !rd_n_i));
    chk("R10 rdata", 32'(rdata_o), (!dir_tx_i && !rd_n_i) ? 32'(ext_rdata_i) : 32'd0);
  endtask

  // inputs already set after a falling edge; check, then let the edge come
  task automatic step();
    #1 compare();
    @(posedge clk);
    if (!rst_n) begin m_addr = '0; m_bhe_n = 1'b1; end
    else if (latch_stb_i) begin m_addr = {mux_hi_i, mux_lo_i}; m_bhe_n = bhe_n_i; end
    @(negedge clk);
  endtask

  task automatic bus_cycle(logic [19:0] a, logic bhe_n, logic [1:0] seg,
                           logic mem, logic wr, logic [15:0] d);
    latch_stb_i = 1; mux_lo_i = a[15:0]; mux_hi_i = a[19:16]; bhe_n_i = bhe_n;
    rd_n_i = 1; wr_n_i = 1; mem_sel_i = mem; dir_tx_i = wr;
    step();
    latch_stb_i = 0; mux_hi_i = {2'b01, seg}; mux_lo_i = d; bhe_n_i = ~bhe_n;
    ext_rdata_i = ~d;
    if (wr) wr_n_i = 0; else rd_n_i = 0;
    step();
    mux_lo_i = d ^ 16'h00ff;
    step();
    rd_n_i = 1; wr_n_i = 1;
    step();
  endtask

  initial begin
    @(negedge clk);
    step(); step();
    rst_n = 1;
    // R1 reset state: held address 0, bank-high inactive
    step();
    bus_cycle(20'hA1234, 1'b0, 2'b11, 1, 0, 16'hBEEF);  // word read, data seg
    bus_cycle(20'h5F0A2, 1'b1, 2'b00, 1, 1, 16'h1357);  // even byte write, extra
    bus_cycle(20'h00333, 1'b0, 2'b01, 0, 0, 16'h2468);  // odd byte io read, stack
    bus_cycle(20'hFFFFF, 1'b0, 2'b10, 0, 1, 16'hC0DE);  // odd byte io write, code
    bus_cycle(20'h12345, 1'b1, 2'b11, 1, 0, 16'h9999);  // R6 invalid bank
    // R8 idle strobes with both selects, R9/R10 mismatched direction
    mem_sel_i = 0; dir_tx_i = 1; rd_n_i = 0; step();
    dir_tx_i = 0; rd_n_i = 1; wr_n_i = 0; step();
    wr_n_i = 1; mem_sel_i = 1; step();
    for (int i = 0; i < 40; i++)
      bus_cycle(20'(i * 37'h1D3F7), 1'(i[1]), 2'(i), 1'(i[2]), 1'(i[0]), 16'(i * 911));
    // R1 reset again mid-run
    rst_n = 0; step(); rst_n = 1; mux_hi_i = 4'h2; step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule